// File: doc/BRIEF.md
# DMA Request Ready Generator

This block drives the two active-low ready strobes that a DMA controller watches when it moves data into and out of one channel of a FIFO-based UART. The block takes no part in the data path. It looks at the occupancy count of the transmit FIFO and of the receive FIFO, at the two programmed trigger levels, at the FIFO enable bit and at the transfer-mode bit. From these it decides when the DMA controller may write characters and when it may read them.

Two transfer styles are supported. In single-character style, a ready output follows the FIFO occupancy directly: the receive strobe is low while any character is waiting, and the transmit strobe is low while the transmit side is empty. In block style, each strobe asserts at a trigger point and stays asserted until the opposite end condition occurs: the transmit FIFO full, or the receive FIFO empty. This lets the DMA controller move a whole burst per request. When the FIFOs are disabled, single-character style is used whatever the mode bit holds. Both strobes come from flops, so neither can glitch.

Top module: `dma_rdy_gen`

## Requirements
- R1: While rst_ni is low, tx_rdy_no and rx_rdy_no are both high (not ready).
- R2: Both outputs are registered. A change on any input reaches the outputs only at the next rising clock edge and never between edges.
- R3: In single-character style, rx_rdy_no is low exactly when the rx_cnt_i sampled at the previous edge is nonzero.
- R4: In single-character style, tx_rdy_no is low exactly when the tx_cnt_i sampled at the previous edge is zero.
- R5: Block style is in effect only when fifo_en_i and blk_mode_i are both 1. With fifo_en_i at 0, the block behaves as in R3 and R4 whatever blk_mode_i holds.
- R6: In block style, tx_rdy_no goes low when the free space (DEPTH minus tx_cnt_i) is at least tx_trig_i and the FIFO is not full.
- R7: In block style, tx_rdy_no goes high when tx_cnt_i equals DEPTH. This release takes priority over R6.
- R8: In block style, rx_rdy_no goes low when rx_cnt_i is nonzero and at least rx_trig_i.
- R9: In block style, rx_rdy_no goes high when rx_cnt_i is zero. This release takes priority over R8.
- R10: In block style, an output whose assert condition and release condition are both false keeps its previous value (hysteresis). After a switch from single-character style, it keeps the value it had on entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFOs enabled |
| blk_mode_i | input | 1 | 1 selects block transfer style |
| tx_cnt_i | input | CNT_W | Characters held in the transmit FIFO |
| rx_cnt_i | input | CNT_W | Characters held in the receive FIFO |
| tx_trig_i | input | CNT_W | Free-space trigger level for the transmit side |
| rx_trig_i | input | CNT_W | Fill trigger level for the receive side |
| tx_rdy_no | output | 1 | Transmit ready, active low |
| rx_rdy_no | output | 1 | Receive ready, active low |

## Verification
The assertions assume that the occupancy counts never exceed DEPTH and that the trigger levels lie between 0 and DEPTH. Under these limits, full and empty are the only release points. The stimulus moves each count as a bounded random walk that is clamped to 0..DEPTH, with occasional jumps straight to empty or full. Trigger levels are drawn only from 0..DEPTH. Mode and enable bits are toggled at random, so that both the hold region and the transfers between styles are visited.

// File: rtl/dma_rdy_pkg.sv
package dma_rdy_pkg;
  typedef enum logic {
    XFER_SINGLE = 1'b0,
    XFER_BLOCK  = 1'b1
  } xfer_mode_e;

  // per-direction decode handed to the hysteresis flop
  typedef struct packed {
    logic set;  // block style assert point
    logic clr;  // block style release point, wins over set
    logic lvl;  // single-character style ready level
  } rdy_cond_t;
endpackage

// File: rtl/dma_rdy_cond.sv
module dma_rdy_cond
  import dma_rdy_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter bit IS_TX = 1'b1
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] trig_i,
  output rdy_cond_t        cond_o
);
  localparam logic [CNT_W:0] DEPTH_W = (CNT_W + 1)'(DEPTH);

  logic empty;
  logic full;
  assign empty = (cnt_i == '0);
  assign full  = ({1'b0, cnt_i} >= DEPTH_W);

  generate
    if (IS_TX) begin : g_tx
      logic [CNT_W:0] free;
      assign free       = full ? '0 : (DEPTH_W - {1'b0, cnt_i});
      assign cond_o.set = (free >= {1'b0, trig_i});
      assign cond_o.clr = full;
      assign cond_o.lvl = empty;
    end else begin : g_rx
      assign cond_o.set = !empty && (cnt_i >= trig_i);
      assign cond_o.clr = empty;
      assign cond_o.lvl = !empty;
    end
  endgenerate
endmodule

// File: rtl/dma_rdy_flop.sv
module dma_rdy_flop
  import dma_rdy_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  xfer_mode_e mode_i,
  input  rdy_cond_t  cond_i,
  output logic       rdy_no
);
  logic active_q;
  logic active_d;

  always_comb begin
    active_d = active_q;
    if (mode_i == XFER_SINGLE) active_d = cond_i.lvl;
    else if (cond_i.clr)       active_d = 1'b0;
    else if (cond_i.set)       active_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= active_d;
  end

  assign rdy_no = ~active_q;

  AST_BLK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == XFER_BLOCK && cond_i.clr) |=> rdy_no);  // R7 R9
  AST_BLK_ASSERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == XFER_BLOCK && cond_i.set && !cond_i.clr) |=> !rdy_no);  // R6 R8
  AST_BLK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == XFER_BLOCK && !cond_i.set && !cond_i.clr) |=> $stable(rdy_no));  // R10
  AST_SINGLE_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == XFER_SINGLE) |=> (rdy_no == !$past(cond_i.lvl)));  // R3 R4
endmodule

// File: rtl/dma_rdy_gen.sv
module dma_rdy_gen
  import dma_rdy_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             blk_mode_i,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic [CNT_W-1:0] tx_trig_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  output logic             tx_rdy_no,
  output logic             rx_rdy_no
);
  xfer_mode_e mode;
  rdy_cond_t  tx_cond;
  rdy_cond_t  rx_cond;

  // FIFOs off forces single-character style
  assign mode = (fifo_en_i && blk_mode_i) ? XFER_BLOCK : XFER_SINGLE;

  dma_rdy_cond #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_TX(1'b1)) u_tx_cond (
    .cnt_i(tx_cnt_i), .trig_i(tx_trig_i), .cond_o(tx_cond)
  );
  dma_rdy_cond #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_TX(1'b0)) u_rx_cond (
    .cnt_i(rx_cnt_i), .trig_i(rx_trig_i), .cond_o(rx_cond)
  );

  dma_rdy_flop u_tx_flop (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode), .cond_i(tx_cond), .rdy_no(tx_rdy_no)
  );
  dma_rdy_flop u_rx_flop (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode), .cond_i(rx_cond), .rdy_no(rx_rdy_no)
  );

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> (tx_rdy_no && rx_rdy_no));  // R1
  AST_RX_EMPTY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_cnt_i == '0) |=> rx_rdy_no);  // R9
  AST_TX_FULL_BLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i && blk_mode_i && tx_cnt_i == CNT_W'(DEPTH)) |=> tx_rdy_no);  // R7
  AST_FIFO_OFF_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |=> (tx_rdy_no == ($past(tx_cnt_i) != '0)));  // R5
endmodule

// File: tb/tb_dma_rdy_gen.sv
module tb_dma_rdy_gen;
  localparam int DEPTH  = 64;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int PERIOD = 10;
  localparam int NCYC   = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b0, blk_mode = 1'b0;
  logic [CNT_W-1:0] tx_cnt = '0, rx_cnt = '0, tx_trig = '0, rx_trig = '0;
  logic tx_rdy_n, rx_rdy_n;

  int vectors = 0;
  int fails = 0;
  bit ex_tx = 0, ex_rx = 0;
  string tag_tx = "R1", tag_rx = "R1";

  always #(PERIOD/2) clk = ~clk;

  dma_rdy_gen #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .blk_mode_i(blk_mode),
    .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt), .tx_trig_i(tx_trig), .rx_trig_i(rx_trig),
    .tx_rdy_no(tx_rdy_n), .rx_rdy_no(rx_rdy_n)
  );

  function automatic bit nxt_tx(bit cur, bit blk, int c, int t);
    if (!blk) return c == 0;            // R4
    if (c >= DEPTH) return 0;           // R7
    if (DEPTH - c >= t) return 1;       // R6
    return cur;                         // R10
  endfunction

  function automatic bit nxt_rx(bit cur, bit blk, int c, int t);
    if (!blk) return c != 0;            // R3
    if (c == 0) return 0;               // R9
    if (c >= t) return 1;               // R8
    return cur;                         // R10
  endfunction

  function automatic string tx_tag(bit blk, bit en, int c, int t);
    if (!en) return "R5";
    if (!blk) return "R4";
    if (c >= DEPTH) return "R7";
    if (DEPTH - c >= t) return "R6";
    return "R10";
  endfunction

  function automatic string rx_tag(bit blk, bit en, int c, int t);
    if (!en) return "R5";
    if (!blk) return "R3";
    if (c == 0) return "R9";
    if (c >= t) return "R8";
    return "R10";
  endfunction

  // reference model, updated on the same edge the DUT samples
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_tx = 0; ex_rx = 0; tag_tx = "R1"; tag_rx = "R1";
    end else begin
      bit blk;
      blk = fifo_en && blk_mode;
      tag_tx = tx_tag(blk, fifo_en, int'(tx_cnt), int'(tx_trig));
      tag_rx = rx_tag(blk, fifo_en, int'(rx_cnt), int'(rx_trig));
      ex_tx = nxt_tx(ex_tx, blk, int'(tx_cnt), int'(tx_trig));
      ex_rx = nxt_rx(ex_rx, blk, int'(rx_cnt), int'(rx_trig));
    end
  end

  task automatic check(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    check({"tx ", tag_tx}, tx_rdy_n, ~ex_tx);
    check({"rx ", tag_rx}, rx_rdy_n, ~ex_rx);
  endtask

  function automatic int walk(int c);
    int r;
    r = c + int'($urandom_range(0, 8)) - 4;
    if ($urandom_range(0, 15) == 0) r = ($urandom_range(0, 1) != 0) ? DEPTH : 0;
    if (r < 0) r = 0;
    if (r > DEPTH) r = DEPTH;
    return r;
  endfunction

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset holds both strobes inactive even with ready-looking inputs
    fifo_en = 1'b1; blk_mode = 1'b0; tx_cnt = '0; rx_cnt = CNT_W'(5);
    repeat (3) @(negedge clk);
    check("R1 tx", tx_rdy_n, 1'b1);
    check("R1 rx", rx_rdy_n, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs();

    // R2: input change mid-cycle does not reach outputs before the edge
    rx_cnt = '0; tx_cnt = CNT_W'(3);
    #1;
    check("R2 rx", rx_rdy_n, 1'b0);
    check("R2 tx", tx_rdy_n, 1'b0);
    @(negedge clk);
    check_outputs();

    // directed block-style sequence: R8 assert, R10 hold, R9 release
    fifo_en = 1'b1; blk_mode = 1'b1; rx_trig = CNT_W'(8); tx_trig = CNT_W'(16);
    rx_cnt = CNT_W'(8); tx_cnt = CNT_W'(48);
    @(negedge clk); check_outputs();
    rx_cnt = CNT_W'(2); tx_cnt = CNT_W'(60);
    @(negedge clk); check_outputs();
    rx_cnt = '0; tx_cnt = CNT_W'(DEPTH);
    @(negedge clk); check_outputs();
    tx_cnt = CNT_W'(60);
    @(negedge clk); check_outputs();
    // R7 beats R6 with trigger 0; R5 with FIFOs off
    tx_trig = '0; tx_cnt = CNT_W'(DEPTH);
    @(negedge clk); check_outputs();
    fifo_en = 1'b0; tx_cnt = '0; rx_cnt = CNT_W'(1);
    @(negedge clk); check_outputs();

    for (int i = 0; i < NCYC; i++) begin
      if ($urandom_range(0, 63) == 0) fifo_en = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 47) == 0) blk_mode = ~blk_mode;
      if ($urandom_range(0, 31) == 0) tx_trig = CNT_W'($urandom_range(0, DEPTH));
      if ($urandom_range(0, 31) == 0) rx_trig = CNT_W'($urandom_range(0, DEPTH));
      tx_cnt = CNT_W'(walk(int'(tx_cnt)));
      rx_cnt = CNT_W'(walk(int'(rx_cnt)));
      @(negedge clk);
      check_outputs();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule